// File: doc/BRIEF.md
# Early-Deasserting Command Admission Controller

This block admits memory requests from a processor-side port into the queue of a DDR2 command scheduler. It drives a ready flag back to the requester. Because the requester sees that flag only two clocks late, the block lowers it as soon as a blocking condition begins. The blocking conditions are a due refresh, a bank or row conflict reported by the command engine, a read/write turnaround, and initialization that has not finished. A request still arriving in the shadow of a falling ready is never lost. It is captured in a small in-order holding queue and issued once the blocking condition has cleared.

Every admitted request passes through the holding queue and leaves on a registered issue port, one per clock at most. A refresh interval counter raises an internal refresh flag. The flag is presented to the command engine as a refresh request and stays up until the engine acknowledges. If a request arrives once ready has been low for longer than the requester's two-clock blind spot, and the queue has no room, the request is dropped and an error pulse is raised.

Top module: `cmd_admit`

## Requirements
- R1: After reset `readyOut` is low. It stays low until `initDone` is sampled high, and rises on the clock edge that samples it. A request captured during initialization is issued on the edge after `readyOut` rises.
- R2: Once initialization is done, the refresh counter advances one per clock. On the edge where it has counted `refreshPeriod` clocks, `refreshReq` rises and `readyOut` falls. `refreshReq` then stays high until `refreshAck` is sampled high.
- R3: Sampling `refreshAck` high while `refreshReq` is high clears `refreshReq` on that edge, and `readyOut` returns high after the same edge if nothing else blocks.
- R4: A request that arrives while `readyOut` is low is held if the queue has space, and it is not issued while the block condition lasts. Held requests are issued one per clock after the condition clears, in arrival order.
- R5: `conflictIn` is registered. `readyOut` is low in the cycle after `conflictIn` is sampled high, and no request issues on an edge whose registered conflict is high.
- R6: When the oldest held request has the other direction from the last issued one (`reqWrite` 1 = write, 0 = read), `readyOut` drops for `TURN_CYC` clocks. The request issues on the edge after that.
- R7: With nothing blocking, a request sampled on one edge appears on `issueValid`/`issueWrite`/`issueAddr` after the next edge, for one cycle.
- R8: A request sampled while `readyOut` has been low for at least three earlier clocks and the queue is full is dropped. `errOut` is high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initDone | input | 1 | Memory initialization has finished (sticky once seen) |
| refreshPeriod | input | REF_W | Refresh interval in clocks (at least 2) |
| refreshAck | input | 1 | Command engine has completed the refresh |
| conflictIn | input | 1 | Command engine reports a bank or row conflict |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqAddr | input | ADDR_W | Request address |
| readyOut | output | 1 | Ready to accept, toward the requester |
| refreshReq | output | 1 | Refresh flag toward the command engine |
| issueValid | output | 1 | Request issued to the scheduler this cycle |
| issueWrite | output | 1 | Direction of the issued request |
| issueAddr | output | ADDR_W | Address of the issued request |
| errOut | output | 1 | Late request dropped on a full queue |

## Verification
The bench builds the block with an 8-bit address, a two-entry queue, a three-clock turnaround and an 8-bit refresh interval. A refresh period of six therefore brings the refresh flag up a few clocks after initialization. Two late requests fill the queue inside the refresh window, so a third one reaches the drop-and-error path. The short turnaround keeps the whole read-after-write gap inside a handful of table rows.

// File: rtl/cmd_admit_pkg.sv
package cmd_admit_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;  // capture the incoming request into the queue
    logic pop;   // issue the oldest held request
  } admit_strobe_t;
endpackage

// File: rtl/cmd_admit_dp.sv
module cmd_admit_dp
  import cmd_admit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  admit_strobe_t     strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              headValid,
  output logic              headWrite,
  output logic              full,
  output logic              issueValid,
  output logic              issueWrite,
  output logic [ADDR_W-1:0] issueAddr
);
  localparam int ENT_W = ADDR_W + 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] head;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  assign head      = slots[rdPtr];
  assign headValid = (count != '0);
  assign headWrite = head[ADDR_W];
  assign full      = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (strobe.push) slots[wrPtr] <= {reqWrite, reqAddr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      if (strobe.push && !strobe.pop)      count <= count + CNT_W'(1);
      else if (strobe.pop && !strobe.push) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      issueWrite <= 1'b0;
      issueAddr  <= '0;
    end else begin
      issueValid <= strobe.pop;
      if (strobe.pop) begin
        issueWrite <= headWrite;
        issueAddr  <= head[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmd_admit_ctl.sv
module cmd_admit_ctl
  import cmd_admit_pkg::*;
#(
  parameter int REF_W    = 16,
  parameter int TURN_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initDone,
  input  logic [REF_W-1:0] refreshPeriod,
  input  logic             refreshAck,
  input  logic             conflictIn,
  input  logic             reqValid,
  input  logic             headValid,
  input  logic             headWrite,
  input  logic             full,
  output admit_strobe_t    strobe,
  output logic             readyOut,
  output logic             refreshReq,
  output logic             errOut
);
  localparam int TURN_W = $clog2(TURN_CYC + 1);
  localparam logic [1:0] LATE_LIMIT = 2'd3;

  logic             initDoneR, refreshPending, conflictR;
  logic [REF_W-1:0] refCnt;
  logic [TURN_W-1:0] turnCnt;
  logic             lastWrite, anyIssued;
  logic [1:0]       lowCnt;
  logic             dirSwap;

  assign readyOut   = initDoneR && !refreshPending && !conflictR && (turnCnt == '0);
  assign dirSwap    = headValid && anyIssued && (headWrite != lastWrite);
  assign strobe     = '{push: reqValid && !full, pop: readyOut && headValid && !dirSwap};
  assign refreshReq = refreshPending;

  // Init latch, conflict sampling, refresh interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initDoneR      <= 1'b0;
      conflictR      <= 1'b0;
      refreshPending <= 1'b0;
      refCnt         <= '0;
    end else begin
      conflictR <= conflictIn;
      if (initDone) initDoneR <= 1'b1;
      if (refreshPending) begin
        if (refreshAck) refreshPending <= 1'b0;
      end else if (initDoneR) begin
        if (refCnt == refreshPeriod - REF_W'(1)) begin
          refreshPending <= 1'b1;
          refCnt         <= '0;
        end else begin
          refCnt <= refCnt + REF_W'(1);
        end
      end
    end
  end

  // Direction tracking and turnaround gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turnCnt   <= '0;
      lastWrite <= 1'b0;
      anyIssued <= 1'b0;
    end else begin
      if (turnCnt != '0) begin
        turnCnt <= turnCnt - TURN_W'(1);
      end else if (initDoneR && dirSwap) begin
        turnCnt   <= TURN_W'(TURN_CYC);
        lastWrite <= headWrite;
      end
      if (strobe.pop) begin
        lastWrite <= headWrite;
        anyIssued <= 1'b1;
      end
    end
  end

  // Late-request window and overflow error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      errOut <= 1'b0;
    end else begin
      if (readyOut)                  lowCnt <= '0;
      else if (lowCnt != LATE_LIMIT) lowCnt <= lowCnt + 2'd1;
      errOut <= reqValid && full && (lowCnt == LATE_LIMIT);
    end
  end
endmodule

// File: rtl/cmd_admit.sv
module cmd_admit
  import cmd_admit_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DEPTH    = 2,
  parameter int REF_W    = 16,
  parameter int TURN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic [REF_W-1:0]  refreshPeriod,
  input  logic              refreshAck,
  input  logic              conflictIn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              readyOut,
  output logic              refreshReq,
  output logic              issueValid,
  output logic              issueWrite,
  output logic [ADDR_W-1:0] issueAddr,
  output logic              errOut
);
  admit_strobe_t strobe;
  logic headValid, headWrite, full;

  cmd_admit_ctl #(.REF_W(REF_W), .TURN_CYC(TURN_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .initDone(initDone), .refreshPeriod(refreshPeriod),
    .refreshAck(refreshAck), .conflictIn(conflictIn), .reqValid(reqValid),
    .headValid(headValid), .headWrite(headWrite), .full(full),
    .strobe(strobe), .readyOut(readyOut), .refreshReq(refreshReq), .errOut(errOut)
  );

  cmd_admit_dp #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .headValid(headValid), .headWrite(headWrite), .full(full),
    .issueValid(issueValid), .issueWrite(issueWrite), .issueAddr(issueAddr)
  );
endmodule

// File: rtl/cmd_admit_chk.sv
module cmd_admit_chk (
  input logic clk,
  input logic rstN,
  input logic readyOut,
  input logic refreshReq,
  input logic refreshAck,
  input logic conflictIn,
  input logic reqValid,
  input logic issueValid,
  input logic errOut
);
  // R2
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && !refreshAck |=> refreshReq);

  // R3
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq && refreshAck |=> !refreshReq);

  // R5
  conflict_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictIn |=> !readyOut);

  // R4
  issue_when_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueValid) |-> $past(readyOut));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $past(reqValid) && !$past(readyOut));
endmodule

bind cmd_admit cmd_admit_chk u_chk (
  .clk(clk), .rstN(rstN), .readyOut(readyOut), .refreshReq(refreshReq),
  .refreshAck(refreshAck), .conflictIn(conflictIn), .reqValid(reqValid),
  .issueValid(issueValid), .errOut(errOut)
);

// File: tb/cmd_admit_bench.sv
module cmd_admit_bench;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initDone = 1'b0;
  logic [7:0] refreshPeriod = 8'd200;
  logic refreshAck = 1'b0;
  logic conflictIn = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic readyOut, refreshReq, issueValid, issueWrite, errOut;
  logic [ADDR_W-1:0] issueAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmd_admit #(.ADDR_W(ADDR_W), .DEPTH(2), .REF_W(8), .TURN_CYC(3)) u_cmd_admit (
    .clk(clk), .rstN(rstN), .initDone(initDone), .refreshPeriod(refreshPeriod),
    .refreshAck(refreshAck), .conflictIn(conflictIn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .readyOut(readyOut),
    .refreshReq(refreshReq), .issueValid(issueValid), .issueWrite(issueWrite),
    .issueAddr(issueAddr), .errOut(errOut)
  );

  // {valid, write, addr, conflict, expReady, expIssue, expAddr}
  localparam logic [20:0] VEC [14] = '{
    {1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00},  // R7 capture
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h11},  // R7 issue
    {1'b1, 1'b1, 8'h22, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22},  // R5 conflict sampled
    {1'b1, 1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 8'h00},  // R4 held
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h33},  // R4 released
    {1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 1'b0, 8'h00},  // R6 read after write
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h44}   // R6 issued
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, return at next falling edge
  task automatic step(input logic v, input logic w, input logic [7:0] a,
                      input logic c, input logic ack);
    reqValid = v; reqWrite = w; reqAddr = a; conflictIn = c; refreshAck = ack;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0; initDone = 1'b0;
    reqValid = 1'b0; conflictIn = 1'b0; refreshAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Reset state and initialization (R1)
    refreshPeriod = 8'd200;
    doReset();
    chk("R1 reset ready", readyOut, 0);
    chk("R1 reset issue", issueValid, 0);
    chk("R2 reset refresh", refreshReq, 0);
    chk("R8 reset err", errOut, 0);
    step(1'b1, 1'b1, 8'h5A, 1'b0, 1'b0);
    chk("R1 ready low in init", readyOut, 0);
    idle();
    idle();
    chk("R1 held during init", issueValid, 0);
    initDone = 1'b1;
    idle();
    chk("R1 ready after init", readyOut, 1);
    chk("R1 no issue same edge", issueValid, 0);
    idle();
    chk("R1 held issued", issueValid, 1);
    chk("R1 held addr", issueAddr, 8'h5A);
    chk("R7 held write", issueWrite, 1);

    // Vector table: capture, conflict, turnaround
    doReset();
    initDone = 1'b1;
    idle();
    chk("R1 ready table start", readyOut, 1);
    for (int i = 0; i < 14; i++) begin
      logic [20:0] vec;
      vec = VEC[i];
      step(vec[20], vec[19], vec[18:11], vec[10], 1'b0);
      chk($sformatf("R4 R5 R6 R7 row %0d ready", i), readyOut, vec[9]);
      chk($sformatf("R4 R5 R6 R7 row %0d issue", i), issueValid, vec[8]);
      if (vec[8]) chk($sformatf("R7 row %0d addr", i), issueAddr, vec[7:0]);
    end
    chk("R6 read direction", issueWrite, 0);

    // Refresh, late requests, overflow
    refreshPeriod = 8'd6;
    doReset();
    initDone = 1'b1;
    idle();                                     // E0
    for (int k = 1; k <= 5; k++) begin
      idle();
      chk($sformatf("R2 before due %0d", k), refreshReq, 0);
      chk($sformatf("R2 ready before due %0d", k), readyOut, 1);
    end
    idle();                                     // E6
    chk("R2 refresh due", refreshReq, 1);
    chk("R2 ready dropped", readyOut, 0);
    step(1'b1, 1'b1, 8'hA1, 1'b0, 1'b0);        // E7
    chk("R4 late held A1", issueValid, 0);
    idle();                                     // E8
    step(1'b1, 1'b1, 8'hA2, 1'b0, 1'b0);        // E9
    chk("R8 no err in window", errOut, 0);
    step(1'b1, 1'b1, 8'hA3, 1'b0, 1'b0);        // E10
    chk("R8 err on overflow", errOut, 1);
    chk("R4 still held", issueValid, 0);
    idle();                                     // E11
    chk("R8 err one cycle", errOut, 0);
    chk("R2 refresh holds", refreshReq, 1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);        // E12
    chk("R3 refresh cleared", refreshReq, 0);
    chk("R3 ready back", readyOut, 1);
    chk("R4 not before release", issueValid, 0);
    idle();                                     // E13
    chk("R4 first issue", issueValid, 1);
    chk("R4 order first", issueAddr, 8'hA1);
    idle();                                     // E14
    chk("R4 second issue", issueValid, 1);
    chk("R4 order second", issueAddr, 8'hA2);
    idle();                                     // E15
    chk("R8 dropped request", issueValid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule